// File: doc/BRIEF.md
# Table-Lookup Constant Multiplier

This block multiplies an unsigned 8-bit sample by a coefficient fixed when the design is built. It uses no multiplier array. The sample is split into its high and low 4-bit halves. Each half indexes its own 16-entry table, and each entry holds that index times the coefficient, so each table returns a 12-bit partial product. The high partial product is added to the low partial product shifted right by four places. The 12-bit sum becomes the upper twelve product bits. The four least significant bits of the low partial product go straight to the bottom of the product and do not pass through the adder.

A valid strobe travels with the data. With the default build, one register stage sits at the output. A sample offered with the strobe high appears on the product port one clock later, together with a raised output strobe. While the input strobe is low, the product register keeps its contents. The output stage can also be built as a direct pass-through.

Top module: `nibble_rom_mult`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `out_valid` is 0 and `out_prod` is 0.
- R2: When `in_valid` is 1 at a rising clock edge, `out_prod` equals `in_data` × `COEF` (unsigned, 16 bits) after that edge. The default `COEF` is 183.
- R3: `out_valid` after each rising edge equals the value `in_valid` had at that edge. The latency is one clock.
- R4: When `in_valid` is 0 at a rising edge, `out_prod` keeps its previous value, whatever `in_data` carries.
- R5: Product bits [3:0] equal bits [3:0] of (`in_data[3:0]` × `COEF`), the bits that skip the adder.
- R6: The boundary operands 0 and 255 give 0 and 255 × `COEF` (46665 = 16'hB649 by default). An input with a zero high half gives the low-half product alone. An input with a zero low half gives the high-half product times 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| in_valid | input | 1 | Sample strobe |
| in_data | input | 8 | Unsigned multiplicand |
| out_valid | output | 1 | Product strobe, `in_valid` delayed one clock |
| out_prod | output | 16 | Registered product `in_data` × `COEF` |

## Verification
On every cycle the bound assertions check four things. The product matches the multiplicand one clock after each strobe. The output strobe tracks the input strobe. The register is stable when no strobe arrives. The bypassed low nibble agrees with the low-half product. The bench's scenarios show the rest: the cleared state during and right after reset, including a reset asserted mid-stream, and the operand extremes and half-zero operands that exercise the table corners. The bench also shows that the held product survives a changing `in_data` over several idle cycles.

// File: rtl/nrm_pkg.sv
package nrm_pkg;
  // Width of one partial product: a half-word index times the coefficient.
  function automatic int pp_width(input int nib_w, input int coef_w);
    return nib_w + coef_w;
  endfunction
endpackage

// File: rtl/nrm_nib_rom.sv
module nrm_nib_rom #(
  parameter int NIB_W  = 4,
  parameter int COEF_W = 8,
  parameter logic [COEF_W-1:0] COEF = 8'd183,
  localparam int PP_W  = nrm_pkg::pp_width(NIB_W, COEF_W),
  localparam int DEPTH = 1 << NIB_W
) (
  input  logic [NIB_W-1:0] addr,
  output logic [PP_W-1:0]  pp
);
  logic [PP_W-1:0] table_q [DEPTH];

  // Entry k holds k * COEF, computed at elaboration.
  for (genvar k = 0; k < DEPTH; k++) begin : g_entry
    assign table_q[k] = PP_W'(k) * PP_W'(COEF);
  end

  assign pp = table_q[addr];
endmodule

// File: rtl/nrm_pp_join.sv
module nrm_pp_join #(
  parameter int NIB_W  = 4,
  parameter int COEF_W = 8,
  localparam int PP_W   = nrm_pkg::pp_width(NIB_W, COEF_W),
  localparam int PROD_W = PP_W + NIB_W
) (
  input  logic [PP_W-1:0]   pp_hi,
  input  logic [PP_W-1:0]   pp_lo,
  output logic [PROD_W-1:0] prod
);
  logic [PP_W-1:0] upper_sum;

  // High partial product plus the low one aligned down by a nibble.
  assign upper_sum = pp_hi + (pp_lo >> NIB_W);
  // Low nibble of the low partial product bypasses the adder.
  assign prod = {upper_sum, pp_lo[NIB_W-1:0]};
endmodule

// File: rtl/nrm_out_stage.sv
module nrm_out_stage #(
  parameter int  PROD_W  = 16,
  parameter bit  OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld_in,
  input  logic [PROD_W-1:0] prod_in,
  output logic              vld_out,
  output logic [PROD_W-1:0] prod_out
);
  if (OUT_REG) begin : g_reg
    logic              vld_q;
    logic [PROD_W-1:0] prod_q;
    logic [PROD_W-1:0] prod_d;

    // Next-state: load only when a sample is offered.
    always_comb begin
      prod_d = prod_q;
      if (vld_in) prod_d = prod_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q  <= 1'b0;
        prod_q <= '0;
      end else begin
        vld_q  <= vld_in;
        prod_q <= prod_d;
      end
    end

    assign vld_out  = vld_q;
    assign prod_out = prod_q;
  end else begin : g_comb
    assign vld_out  = vld_in;
    assign prod_out = prod_in;
  end
endmodule

// File: rtl/nibble_rom_mult.sv
module nibble_rom_mult #(
  parameter int IN_W   = 8,
  parameter int COEF_W = 8,
  parameter logic [COEF_W-1:0] COEF = 8'd183,
  parameter bit OUT_REG = 1'b1,
  localparam int NIB_W  = IN_W / 2,
  localparam int PP_W   = nrm_pkg::pp_width(NIB_W, COEF_W),
  localparam int PROD_W = IN_W + COEF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [IN_W-1:0]   in_data,
  output logic              out_valid,
  output logic [PROD_W-1:0] out_prod
);
  logic [PP_W-1:0]   pp_hi;
  logic [PP_W-1:0]   pp_lo;
  logic [PROD_W-1:0] prod_c;

  nrm_nib_rom #(.NIB_W(NIB_W), .COEF_W(COEF_W), .COEF(COEF)) u_rom_hi (
    .addr (in_data[IN_W-1:NIB_W]),
    .pp   (pp_hi)
  );

  nrm_nib_rom #(.NIB_W(NIB_W), .COEF_W(COEF_W), .COEF(COEF)) u_rom_lo (
    .addr (in_data[NIB_W-1:0]),
    .pp   (pp_lo)
  );

  nrm_pp_join #(.NIB_W(NIB_W), .COEF_W(COEF_W)) u_join (
    .pp_hi (pp_hi),
    .pp_lo (pp_lo),
    .prod  (prod_c)
  );

  nrm_out_stage #(.PROD_W(PROD_W), .OUT_REG(OUT_REG)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .vld_in   (in_valid),
    .prod_in  (prod_c),
    .vld_out  (out_valid),
    .prod_out (out_prod)
  );
endmodule

// File: rtl/nrm_checker.sv
module nrm_checker #(
  parameter int IN_W   = 8,
  parameter int COEF_W = 8,
  parameter logic [COEF_W-1:0] COEF = 8'd183,
  parameter bit OUT_REG = 1'b1,
  localparam int NIB_W  = IN_W / 2,
  localparam int PROD_W = IN_W + COEF_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [IN_W-1:0]   in_data,
  input logic              out_valid,
  input logic [PROD_W-1:0] out_prod
);
  logic [PROD_W-1:0] full_ref;
  logic [NIB_W-1:0]  low_ref;

  assign full_ref = PROD_W'(in_data) * PROD_W'(COEF);
  assign low_ref  = NIB_W'(PROD_W'(in_data[NIB_W-1:0]) * PROD_W'(COEF));

  if (OUT_REG) begin : g_chk
    // R1
    a_r1_reset_clear: assert property (@(posedge clk)
      $rose(rst_n) |-> (!out_valid && out_prod == '0));
    // R2
    a_r2_product: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_prod == $past(full_ref));
    // R3
    a_r3_valid_hi: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
    a_r3_valid_lo: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
    // R4
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_prod));
    // R5
    a_r5_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_prod[NIB_W-1:0] == $past(low_ref));
  end
endmodule

bind nibble_rom_mult nrm_checker #(
  .IN_W(IN_W), .COEF_W(COEF_W), .COEF(COEF), .OUT_REG(OUT_REG)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_prod  (out_prod)
);

// File: tb/tb_nibble_rom_mult.sv
module tb_nibble_rom_mult;
  localparam int  COEFV = 183;
  localparam int  NV    = 12;
  localparam logic [7:0] VEC [NV] = '{
    8'h00, 8'hFF, 8'h01, 8'h10, 8'h0F, 8'hF0,
    8'h5A, 8'hA5, 8'h80, 8'h08, 8'h37, 8'hC3
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  in_data;
  logic        out_valid;
  logic [15:0] out_prod;
  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  nibble_rom_mult dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_prod(out_prod)
  );

  function automatic logic [15:0] expect_of(input logic [7:0] x);
    return 16'(x) * 16'(COEFV);
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] x);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = x;
    @(negedge clk);
    check("R2 product", out_prod, expect_of(x));
    check("R3 valid", 16'(out_valid), 16'd1);
    check("R5 low nibble", 16'(out_prod[3:0]), 16'(expect_of({4'h0, x[3:0]}) & 16'hF));
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = 8'h00;
    repeat (2) @(negedge clk);
    check("R1 reset valid", 16'(out_valid), 16'd0);
    check("R1 reset prod", out_prod, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {15'd0, out_valid}, 16'd0);

    // Table-driven main function (R2, R3, R5, R6 corners included)
    for (int i = 0; i < NV; i++) apply(VEC[i]);

    // R6 boundaries
    apply(8'hFF); check("R6 max", out_prod, 16'hB649);
    apply(8'h00); check("R6 zero", out_prod, 16'h0000);
    apply(8'h0B); check("R6 high half zero", out_prod, 16'(11 * COEFV));
    apply(8'hB0); check("R6 low half zero", out_prod, 16'(11 * COEFV) << 4);

    // R4 hold while idle with changing data
    apply(8'h9C);
    for (int k = 0; k < 3; k++) begin
      in_valid = 1'b0;
      in_data  = 8'(k * 37 + 5);
      @(negedge clk);
      check("R4 hold", out_prod, expect_of(8'h9C));
      check("R3 idle valid", 16'(out_valid), 16'd0);
    end

    // R1 mid-stream reset
    apply(8'h77);
    in_valid = 1'b1; in_data = 8'h44;
    rst_n = 1'b0;
    #1;
    check("R1 async clear prod", out_prod, 16'd0);
    check("R1 async clear valid", 16'(out_valid), 16'd0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 post reset prod", out_prod, 16'd0);
    apply(8'h44);

    done = 1'b1;
    finish_run();
  end
endmodule